// File: doc/BRIEF.md
# Doorbell mailbox with sender and receiver frames

This block links a sending agent and a receiving agent through a set of doorbell channel windows. Each window holds 32 independent flag bits. The sender raises flags by writing ones to a set register. The receiver reads the flags, hides chosen bits behind a per-bit mask, and drops flags by writing ones to a clear register. Dropping a flag latches a transfer-acknowledge status bit in that window on the sender side, so the sender learns that its doorbell was serviced.

Each frame has its own simple register port: a request, a write enable, an address and write data, with read data returned in the same cycle. Address bit 10 selects the global page when it is 1 and the window page when it is 0. On the window page, bits 9:3 give the window index and bits 2:0 give the register offset. Per-window interrupt conditions are gated by a per-window combine enable on each side. They are packed into four 32-bit combined status words, and each side also gets one combined interrupt line. The number of windows is set by the NUM_WIN parameter, from 1 to 128.

Top module: `dbell_mailbox`

## Requirements
- R1: After reset all flags, masks, acknowledge status bits, acknowledge enables and combine enables read 0, and both s_irq_o and r_irq_o are 0.
- R2: A sender write to window offset 1 (set) raises every flag whose data bit is 1. Bits written as 0 leave their flags unchanged.
- R3: Window offset 0 reads the current flags on both ports. Receiver offset 1 reads the flags ANDed with the inverse of the mask.
- R4: A receiver write of ones to offset 4 sets those mask bits, and a write of ones to offset 5 clears them. Receiver offset 3 reads the mask.
- R5: A receiver write of ones to offset 2 drops those flags. A falling flag sets the sender acknowledge status at sender offset 2, bit 0, on the same edge, and the status holds until it is cleared.
- R6: A sender write with bit 0 set to offset 3 clears the acknowledge status. Sender offset 4 bit 0 is the acknowledge enable. If a new flag falls in the same cycle as an acknowledge clear, the status stays 1.
- R7: If the sender sets and the receiver clears the same bit in the same cycle, the clear is applied first and then the set. The flag stays 1 and no acknowledge is raised.
- R8: Bit 0 of sender offset 5 and bit 0 of receiver offset 6 are the per-window combine enables. A sender combined bit is status AND enable AND combine. A receiver combined bit is (any unmasked flag) AND combine. Each interrupt line is the OR of that side's combined bits.
- R9: Global offsets 2 to 5 read combined words 0 to 3 of the port's side. Window n appears at bit n mod 32 of word n div 32.
- R10: Global offset 0 reads a frame identifier in bits 3:0 (0 on the sender port, 1 on the receiver port) and the value 2 in bits 7:4. Global offset 1 reads NUM_WIN-1 in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| s_req_i | input | 1 | Sender port access strobe |
| s_we_i | input | 1 | Sender port write enable |
| s_addr_i | input | 11 | Sender port address |
| s_wdata_i | input | 32 | Sender port write data |
| s_rdata_o | output | 32 | Sender port read data, same cycle |
| r_req_i | input | 1 | Receiver port access strobe |
| r_we_i | input | 1 | Receiver port write enable |
| r_addr_i | input | 11 | Receiver port address |
| r_wdata_i | input | 32 | Receiver port write data |
| r_rdata_o | output | 32 | Receiver port read data, same cycle |
| s_irq_o | output | 1 | Sender combined interrupt |
| r_irq_o | output | 1 | Receiver combined interrupt |

## Verification
Two collisions can fall in the same cycle because the two ports are driven independently. The first is a sender set against a receiver clear of the same flag bit. The second is a sender acknowledge clear against a fresh receiver clear that drops another flag in the same window. The bench provokes each one by driving both ports on the same clock edge. For the first it expects the flag to stay 1 and the acknowledge to stay 0. For the second it expects the acknowledge status to remain 1.

// File: rtl/db_mbox_pkg.sv
package db_mbox_pkg;
  localparam int FLAG_W    = 32;
  localparam int MAX_WIN   = 128;
  localparam int WIN_AW    = 7;
  localparam int AW        = WIN_AW + 4;
  localparam int CMB_WORDS = MAX_WIN / FLAG_W;
  localparam logic [3:0] MAJOR_REV = 4'd2;

  // sender window offsets
  localparam logic [2:0] S_ST = 3'd0, S_SET = 3'd1, S_ACK_ST = 3'd2,
                         S_ACK_CLR = 3'd3, S_ACK_EN = 3'd4, S_CTRL = 3'd5;
  // receiver window offsets
  localparam logic [2:0] R_ST = 3'd0, R_STM = 3'd1, R_CLR = 3'd2,
                         R_MSK_ST = 3'd3, R_MSK_SET = 3'd4, R_MSK_CLR = 3'd5,
                         R_CTRL = 3'd6;
  // global page offsets
  localparam logic [2:0] G_ID = 3'd0, G_CFG = 3'd1, G_CMB0 = 3'd2,
                         G_CMB1 = 3'd3, G_CMB2 = 3'd4, G_CMB3 = 3'd5;
endpackage

// File: rtl/db_window.sv
module db_window
  import db_mbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  input  logic [FLAG_W-1:0] msk_set_i,
  input  logic [FLAG_W-1:0] msk_clr_i,
  input  logic              ack_clr_i,
  input  logic              ack_en_we_i,
  input  logic              ack_en_i,
  input  logic              s_ctrl_we_i,
  input  logic              s_ctrl_i,
  input  logic              r_ctrl_we_i,
  input  logic              r_ctrl_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] mask_o,
  output logic              ack_st_o,
  output logic              ack_en_o,
  output logic              s_cmb_o,
  output logic              r_cmb_o,
  output logic              s_pend_o,
  output logic              r_pend_o
);
  logic [FLAG_W-1:0] flags_q, flags_d, mask_q;
  logic ack_st_q, ack_en_q, s_cmb_q, r_cmb_q, fell;

  // clear first, then set
  assign flags_d = (flags_q & ~clr_i) | set_i;
  assign fell    = |(flags_q & ~flags_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q  <= '0;
      mask_q   <= '0;
      ack_st_q <= 1'b0;
      ack_en_q <= 1'b0;
      s_cmb_q  <= 1'b0;
      r_cmb_q  <= 1'b0;
    end else begin
      flags_q  <= flags_d;
      mask_q   <= (mask_q | msk_set_i) & ~msk_clr_i;
      ack_st_q <= fell | (ack_st_q & ~ack_clr_i);
      if (ack_en_we_i) ack_en_q <= ack_en_i;
      if (s_ctrl_we_i) s_cmb_q  <= s_ctrl_i;
      if (r_ctrl_we_i) r_cmb_q  <= r_ctrl_i;
    end
  end

  assign flags_o  = flags_q;
  assign mask_o   = mask_q;
  assign ack_st_o = ack_st_q;
  assign ack_en_o = ack_en_q;
  assign s_cmb_o  = s_cmb_q;
  assign r_cmb_o  = r_cmb_q;
  assign s_pend_o = ack_st_q & ack_en_q & s_cmb_q;
  assign r_pend_o = (|(flags_q & ~mask_q)) & r_cmb_q;

  p_set_sticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));

  p_clr_drops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));

  p_ack_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(flags_q) & ~flags_q)) |-> ack_st_q);

  p_ack_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_st_q && !ack_clr_i) |=> ack_st_q);

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & clr_i)) |=> ((flags_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));
endmodule

// File: rtl/db_combine.sv
module db_combine
  import db_mbox_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WIN-1:0]   s_pend_i,
  input  logic [NUM_WIN-1:0]   r_pend_i,
  output logic [MAX_WIN-1:0]   s_bits_o,
  output logic [MAX_WIN-1:0]   r_bits_o,
  output logic                 s_irq_o,
  output logic                 r_irq_o
);
  for (genvar n = 0; n < MAX_WIN; n++) begin : g_bit
    if (n < NUM_WIN) begin : g_used
      assign s_bits_o[n] = s_pend_i[n];
      assign r_bits_o[n] = r_pend_i[n];
    end else begin : g_pad
      assign s_bits_o[n] = 1'b0;
      assign r_bits_o[n] = 1'b0;
    end
  end

  assign s_irq_o = |s_bits_o;
  assign r_irq_o = |r_bits_o;

  p_s_irq_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_pend_i == '0) |-> !s_irq_o);
  p_r_irq_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_pend_i != '0) |-> r_irq_o);
endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
  import db_mbox_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_req_i,
  input  logic              s_we_i,
  input  logic [AW-1:0]     s_addr_i,
  input  logic [FLAG_W-1:0] s_wdata_i,
  output logic [FLAG_W-1:0] s_rdata_o,
  input  logic              r_req_i,
  input  logic              r_we_i,
  input  logic [AW-1:0]     r_addr_i,
  input  logic [FLAG_W-1:0] r_wdata_i,
  output logic [FLAG_W-1:0] r_rdata_o,
  output logic              s_irq_o,
  output logic              r_irq_o
);
  localparam logic [7:0] CFG_VAL = 8'(NUM_WIN - 1);

  logic              s_glob, r_glob, s_wr, r_wr;
  logic [WIN_AW-1:0] s_win, r_win;
  logic [2:0]        s_reg, r_reg;

  assign s_glob = s_addr_i[AW-1];
  assign r_glob = r_addr_i[AW-1];
  assign s_win  = s_addr_i[AW-2:3];
  assign r_win  = r_addr_i[AW-2:3];
  assign s_reg  = s_addr_i[2:0];
  assign r_reg  = r_addr_i[2:0];
  assign s_wr   = s_req_i & s_we_i & ~s_glob;
  assign r_wr   = r_req_i & r_we_i & ~r_glob;

  logic [FLAG_W-1:0] flags [NUM_WIN];
  logic [FLAG_W-1:0] mask  [NUM_WIN];
  logic [NUM_WIN-1:0] ack_st, ack_en, s_cmb, r_cmb, s_pend, r_pend;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic hs, hr;
    assign hs = s_wr && (s_win == WIN_AW'(w));
    assign hr = r_wr && (r_win == WIN_AW'(w));

    db_window i_win (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .set_i       ((hs && s_reg == S_SET) ? s_wdata_i : '0),
      .clr_i       ((hr && r_reg == R_CLR) ? r_wdata_i : '0),
      .msk_set_i   ((hr && r_reg == R_MSK_SET) ? r_wdata_i : '0),
      .msk_clr_i   ((hr && r_reg == R_MSK_CLR) ? r_wdata_i : '0),
      .ack_clr_i   (hs && s_reg == S_ACK_CLR && s_wdata_i[0]),
      .ack_en_we_i (hs && s_reg == S_ACK_EN),
      .ack_en_i    (s_wdata_i[0]),
      .s_ctrl_we_i (hs && s_reg == S_CTRL),
      .s_ctrl_i    (s_wdata_i[0]),
      .r_ctrl_we_i (hr && r_reg == R_CTRL),
      .r_ctrl_i    (r_wdata_i[0]),
      .flags_o     (flags[w]),
      .mask_o      (mask[w]),
      .ack_st_o    (ack_st[w]),
      .ack_en_o    (ack_en[w]),
      .s_cmb_o     (s_cmb[w]),
      .r_cmb_o     (r_cmb[w]),
      .s_pend_o    (s_pend[w]),
      .r_pend_o    (r_pend[w])
    );
  end

  logic [MAX_WIN-1:0] s_bits, r_bits;

  db_combine #(.NUM_WIN(NUM_WIN)) i_cmb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .s_pend_i (s_pend),
    .r_pend_i (r_pend),
    .s_bits_o (s_bits),
    .r_bits_o (r_bits),
    .s_irq_o  (s_irq_o),
    .r_irq_o  (r_irq_o)
  );

  function automatic logic [FLAG_W-1:0] glob_rd(input logic [2:0] rg,
                                                input logic [3:0] frame,
                                                input logic [MAX_WIN-1:0] bits);
    case (rg)
      G_ID:    glob_rd = {24'd0, MAJOR_REV, frame};
      G_CFG:   glob_rd = {24'd0, CFG_VAL};
      G_CMB0:  glob_rd = bits[31:0];
      G_CMB1:  glob_rd = bits[63:32];
      G_CMB2:  glob_rd = bits[95:64];
      G_CMB3:  glob_rd = bits[127:96];
      default: glob_rd = '0;
    endcase
  endfunction

  always_comb begin
    s_rdata_o = '0;
    if (s_glob) s_rdata_o = glob_rd(s_reg, 4'd0, s_bits);
    else begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (s_win == WIN_AW'(w)) begin
          case (s_reg)
            S_ST:     s_rdata_o = flags[w];
            S_ACK_ST: s_rdata_o = {31'd0, ack_st[w]};
            S_ACK_EN: s_rdata_o = {31'd0, ack_en[w]};
            S_CTRL:   s_rdata_o = {31'd0, s_cmb[w]};
            default:  s_rdata_o = '0;
          endcase
        end
      end
    end
  end

  always_comb begin
    r_rdata_o = '0;
    if (r_glob) r_rdata_o = glob_rd(r_reg, 4'd1, r_bits);
    else begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (r_win == WIN_AW'(w)) begin
          case (r_reg)
            R_ST:     r_rdata_o = flags[w];
            R_STM:    r_rdata_o = flags[w] & ~mask[w];
            R_MSK_ST: r_rdata_o = mask[w];
            R_CTRL:   r_rdata_o = {31'd0, r_cmb[w]};
            default:  r_rdata_o = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: tb/test_dbell_mailbox.sv
`timescale 1ns/1ps
module test_dbell_mailbox;
  localparam int NW = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_req = 0, s_we = 0, r_req = 0, r_we = 0;
  logic [10:0] s_addr = '0, r_addr = '0;
  logic [31:0] s_wdata = '0, r_wdata = '0, s_rdata, r_rdata;
  logic s_irq, r_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbell_mailbox #(.NUM_WIN(NW)) i_dbell_mailbox (
    .clk_i(clk), .rst_ni(rst_n),
    .s_req_i(s_req), .s_we_i(s_we), .s_addr_i(s_addr), .s_wdata_i(s_wdata), .s_rdata_o(s_rdata),
    .r_req_i(r_req), .r_we_i(r_we), .r_addr_i(r_addr), .r_wdata_i(r_wdata), .r_rdata_o(r_rdata),
    .s_irq_o(s_irq), .r_irq_o(r_irq));

  typedef struct packed {
    logic        side;  // 0 sender, 1 receiver
    logic        we;
    logic [10:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  tag;
  } vec_t;

  localparam vec_t VECS [19] = '{
    '{1'b0, 1'b0, 11'd1024, 32'h0,   32'h20,  4'd10}, // R10 sender id
    '{1'b1, 1'b0, 11'd1024, 32'h0,   32'h21,  4'd10}, // R10 receiver id
    '{1'b0, 1'b0, 11'd1025, 32'h0,   32'd39,  4'd10}, // R10 count
    '{1'b0, 1'b0, 11'd0,    32'h0,   32'h0,   4'd1},  // R1
    '{1'b0, 1'b1, 11'd1,    32'hA5,  32'h0,   4'd2},  // R2 set
    '{1'b1, 1'b0, 11'd0,    32'h0,   32'hA5,  4'd3},  // R3 rx view
    '{1'b0, 1'b1, 11'd1,    32'h100, 32'h0,   4'd2},
    '{1'b0, 1'b0, 11'd0,    32'h0,   32'h1A5, 4'd2},  // R2 others kept
    '{1'b1, 1'b1, 11'd4,    32'h0F,  32'h0,   4'd4},  // R4 mask set
    '{1'b1, 1'b0, 11'd3,    32'h0,   32'h0F,  4'd4},
    '{1'b1, 1'b0, 11'd1,    32'h0,   32'h1A0, 4'd3},  // R3 masked
    '{1'b1, 1'b1, 11'd5,    32'h03,  32'h0,   4'd4},  // R4 mask clr
    '{1'b1, 1'b0, 11'd3,    32'h0,   32'h0C,  4'd4},
    '{1'b0, 1'b0, 11'd2,    32'h0,   32'h0,   4'd5},  // R5 no ack yet
    '{1'b1, 1'b1, 11'd2,    32'h05,  32'h0,   4'd5},  // R5 clear
    '{1'b0, 1'b0, 11'd0,    32'h0,   32'h1A0, 4'd5},
    '{1'b0, 1'b0, 11'd2,    32'h0,   32'h1,   4'd5},  // R5 ack
    '{1'b0, 1'b1, 11'd3,    32'h1,   32'h0,   4'd6},  // R6 ack clr
    '{1'b0, 1'b0, 11'd2,    32'h0,   32'h0,   4'd6}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr2(input logic sd, input logic sr, input logic [10:0] sa, input logic [31:0] swd,
                     input logic [10:0] ra, input logic [31:0] rwd);
    @(negedge clk);
    s_req = sd; s_we = sd; s_addr = sa; s_wdata = swd;
    r_req = sr; r_we = sr; r_addr = ra; r_wdata = rwd;
    @(negedge clk);
    s_req = 0; s_we = 0; r_req = 0; r_we = 0;
  endtask

  task automatic s_wr(input logic [10:0] a, input logic [31:0] d); wr2(1, 0, a, d, '0, '0); endtask
  task automatic r_wr(input logic [10:0] a, input logic [31:0] d); wr2(0, 1, '0, '0, a, d); endtask

  task automatic s_chk(input string rq, input logic [10:0] a, input logic [31:0] exp);
    s_addr = a; #1; chk(rq, s_rdata, exp);
  endtask
  task automatic r_chk(input string rq, input logic [10:0] a, input logic [31:0] exp);
    r_addr = a; #1; chk(rq, r_rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 s_irq", {31'd0, s_irq}, 32'd0);
    chk("R1 r_irq", {31'd0, r_irq}, 32'd0);
    r_chk("R1 mask", 11'd3, 32'h0);

    for (int i = 0; i < 19; i++) begin
      if (VECS[i].we) begin
        if (VECS[i].side) r_wr(VECS[i].addr, VECS[i].data);
        else s_wr(VECS[i].addr, VECS[i].data);
      end else if (VECS[i].side)
        r_chk($sformatf("R%0d vec %0d", VECS[i].tag, i), VECS[i].addr, VECS[i].exp);
      else
        s_chk($sformatf("R%0d vec %0d", VECS[i].tag, i), VECS[i].addr, VECS[i].exp);
    end

    // R8 and R9: receiver side, window 35 -> word 1 bit 3
    r_wr(11'd286, 32'h1);
    s_wr(11'd281, 32'h80);
    chk("R8 r_irq on", {31'd0, r_irq}, 32'd1);
    r_chk("R9 rx word1", 11'd1027, 32'h8);
    r_chk("R9 rx word0", 11'd1026, 32'h0);
    r_wr(11'd284, 32'h80);
    chk("R8 r_irq masked", {31'd0, r_irq}, 32'd0);
    // sender side of window 35
    s_wr(11'd284, 32'h1);
    s_wr(11'd285, 32'h1);
    r_wr(11'd285, 32'h80);
    chk("R8 s_irq idle", {31'd0, s_irq}, 32'd0);
    r_wr(11'd282, 32'h80);
    chk("R8 s_irq on", {31'd0, s_irq}, 32'd1);
    s_chk("R9 tx word1", 11'd1027, 32'h8);
    s_wr(11'd283, 32'h1);
    chk("R8 s_irq off", {31'd0, s_irq}, 32'd0);
    chk("R8 r_irq off", {31'd0, r_irq}, 32'd0);

    // R7: same-cycle set and clear of one bit in window 2
    s_wr(11'd17, 32'h1);
    wr2(1, 1, 11'd17, 32'h1, 11'd18, 32'h1);
    s_chk("R7 flag stays", 11'd16, 32'h1);
    s_chk("R7 no ack", 11'd18, 32'h0);

    // R6: ack clear collides with a new fall in window 3
    s_wr(11'd25, 32'h3);
    r_wr(11'd26, 32'h1);
    s_chk("R5 ack w3", 11'd26, 32'h1);
    wr2(1, 1, 11'd27, 32'h1, 11'd26, 32'h2);
    s_chk("R6 ack kept", 11'd26, 32'h1);
    s_chk("R6 flags gone", 11'd24, 32'h0);
    s_wr(11'd27, 32'h1);
    s_chk("R6 ack cleared", 11'd26, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule